// File: doc/BRIEF.md
# UART Interrupt Status and Routing

This block keeps the interrupt state of a UART: an eleven-bit raw status word, a matching enable mask, and the logic that sets and clears the status bits. Event sources elsewhere in the UART set status bits with one-cycle strobes. Some sources may also clear their own bit in hardware. Software can also set the transmit bit, because a write to the transmit data address raises it.

Software uses a single-cycle register port. It writes the mask. It clears status bits by writing ones to a clear address. It reads back the raw word and the masked word.

Six interrupt lines leave the block. Each one is high when the masked status holds a set bit inside its own fixed group. One line covers all eleven sources. The other five cover receive, transmit, receive timeout, the four modem-status bits and the four error bits.

Status bit positions: ring indicator 0, clear-to-send 1, carrier detect 2, data-set-ready 3, receive 4, transmit 5, receive timeout 6, framing error 7, parity error 8, break 9, overrun 10. Register addresses: 0 transmit data, 1 mask, 2 raw status, 3 masked status, 4 clear.

Top module: `uart_irq_router`

## Requirements
- R1: After reset the raw status and the mask are zero, and all six interrupt lines are low.
- R2: A write to address 1 loads bits 10:0 of the write data into the mask. A read of address 1 returns the mask, with bits above 10 reading as zero.
- R3: A read of address 2 returns the raw status. A read of address 3 returns the raw status ANDed with the mask.
- R4: A 1 on bit i of `ev_set` makes raw status bit i equal to 1 after the next clock edge.
- R5: A write to address 4 clears every raw status bit where the write data holds a 1. Bits where the write data holds a 0 are left unchanged.
- R6: A 1 on bit i of `ev_clr` clears raw status bit i at the next clock edge.
- R7: When a set strobe and a clear hit the same bit in the same cycle, the bit ends up set. This holds whether the clear comes from a software write or from `ev_clr`.
- R8: A read of address 4 returns zero. Writes to addresses 2 and 3 leave both the raw status and the mask unchanged.
- R9: A write to address 0 sets raw status bit 5, the transmit bit.
- R10: Each interrupt line is high when the masked status has a set bit in its group. The groups are: `irq_all` bits 10:0, `irq_rx` bit 4, `irq_tx` bit 5, `irq_rtim` bit 6, `irq_modem` bits 3:0, `irq_err` bits 10:7.
- R11: The interrupt lines follow a change of status or mask in the cycle right after the clock edge that makes the change. No further register stage sits in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W (3) | Register address |
| reg_wen | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | DATA_W (16) | Write data |
| reg_rdata | output | DATA_W (16) | Read data for `reg_addr`, combinational |
| ev_set | input | 11 | Per-bit status set strobes from event sources |
| ev_clr | input | 11 | Per-bit hardware clear strobes |
| irq_all | output | 1 | Combined interrupt |
| irq_rx | output | 1 | Receive interrupt |
| irq_tx | output | 1 | Transmit interrupt |
| irq_rtim | output | 1 | Receive-timeout interrupt |
| irq_modem | output | 1 | Modem-status interrupt |
| irq_err | output | 1 | Error interrupt |

## Verification
Every write, set strobe and clear strobe is taken at one rising edge, and its result is held in the status or mask register. The interrupt lines and the read data are plain combinational functions of those registers. So any effect is due in the cycle right after the capturing edge, and a read returns the current contents within the same cycle. The bench changes inputs on the falling edge and releases them one full period later. It samples outputs at the following falling edge, half a period after the register has changed. It reads by setting the address on a falling edge and sampling one nanosecond later.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int NSRC = 11;
  localparam int NOUT = 6;

  // status bit positions
  localparam int B_RI   = 0;
  localparam int B_CTS  = 1;
  localparam int B_DCD  = 2;
  localparam int B_DSR  = 3;
  localparam int B_RX   = 4;
  localparam int B_TX   = 5;
  localparam int B_RT   = 6;
  localparam int B_FE   = 7;
  localparam int B_PE   = 8;
  localparam int B_BE   = 9;
  localparam int B_OE   = 10;

  // register addresses
  localparam int A_DATA = 0;
  localparam int A_MASK = 1;
  localparam int A_RAW  = 2;
  localparam int A_MSKD = 3;
  localparam int A_CLR  = 4;

  // output line indices
  localparam int O_ALL = 0;
  localparam int O_RX  = 1;
  localparam int O_TX  = 2;
  localparam int O_RT  = 3;
  localparam int O_MS  = 4;
  localparam int O_ERR = 5;

  typedef logic [NSRC-1:0] irq_vec_t;

  function automatic irq_vec_t bit_of(input int pos);
    irq_vec_t v;
    v = '0;
    v[pos] = 1'b1;
    return v;
  endfunction

  function automatic irq_vec_t group_mask(input int line);
    irq_vec_t ms, er;
    ms = bit_of(B_RI) | bit_of(B_CTS) | bit_of(B_DCD) | bit_of(B_DSR);
    er = bit_of(B_FE) | bit_of(B_PE) | bit_of(B_BE) | bit_of(B_OE);
    case (line)
      O_ALL:   return ms | er | bit_of(B_RX) | bit_of(B_TX) | bit_of(B_RT);
      O_RX:    return bit_of(B_RX);
      O_TX:    return bit_of(B_TX);
      O_RT:    return bit_of(B_RT);
      O_MS:    return ms;
      default: return er;
    endcase
  endfunction

  // next raw value: clears first, then sets override them
  function automatic irq_vec_t raw_next(input irq_vec_t cur, input irq_vec_t clr,
                                        input irq_vec_t set);
    return (cur & ~clr) | set;
  endfunction

endpackage

// File: rtl/uart_irq_status.sv
module uart_irq_status
  import uart_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  irq_vec_t set_i,
  input  irq_vec_t clr_i,
  output irq_vec_t raw_o
);

  irq_vec_t raw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= raw_next(raw_q, clr_i, set_i);
  end

  assign raw_o = raw_q;

endmodule

// File: rtl/uart_irq_mask.sv
module uart_irq_mask
  import uart_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load_i,
  input  irq_vec_t val_i,
  output irq_vec_t mask_o
);

  irq_vec_t mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mask_q <= '0;
    else if (load_i) mask_q <= val_i;
  end

  assign mask_o = mask_q;

endmodule

// File: rtl/uart_irq_fanout.sv
module uart_irq_fanout
  import uart_irq_pkg::*;
#(
  parameter int LINES = NOUT
) (
  input  irq_vec_t         masked_i,
  output logic [LINES-1:0] line_o
);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    localparam irq_vec_t GMASK = group_mask(g);
    assign line_o[g] = |(masked_i & GMASK);
  end

endmodule

// File: rtl/uart_irq_router.sv
module uart_irq_router
  import uart_irq_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wen,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NSRC-1:0]   ev_set,
  input  logic [NSRC-1:0]   ev_clr,
  output logic              irq_all,
  output logic              irq_rx,
  output logic              irq_tx,
  output logic              irq_rtim,
  output logic              irq_modem,
  output logic              irq_err
);

  localparam int PAD_W = DATA_W - NSRC;

  // named internal events, visible to the bound checker
  logic     wr_data, wr_mask, wr_clr;
  irq_vec_t sw_clr, tx_set, set_all, clr_all;
  irq_vec_t raw_q, mask_q, masked;
  logic [NOUT-1:0] lines;
  logic     unused_wdata_hi;

  assign wr_data = reg_wen && (reg_addr == ADDR_W'(A_DATA));
  assign wr_mask = reg_wen && (reg_addr == ADDR_W'(A_MASK));
  assign wr_clr  = reg_wen && (reg_addr == ADDR_W'(A_CLR));

  assign sw_clr  = wr_clr  ? reg_wdata[NSRC-1:0] : '0;
  assign tx_set  = wr_data ? bit_of(B_TX) : '0;
  assign set_all = ev_set | tx_set;
  assign clr_all = ev_clr | sw_clr;
  assign unused_wdata_hi = ^reg_wdata[DATA_W-1:NSRC];

  uart_irq_status u_status (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (set_all),
    .clr_i (clr_all),
    .raw_o (raw_q)
  );

  uart_irq_mask u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (wr_mask),
    .val_i  (reg_wdata[NSRC-1:0]),
    .mask_o (mask_q)
  );

  assign masked = raw_q & mask_q;

  uart_irq_fanout #(.LINES(NOUT)) u_fanout (
    .masked_i (masked),
    .line_o   (lines)
  );

  assign irq_all   = lines[O_ALL];
  assign irq_rx    = lines[O_RX];
  assign irq_tx    = lines[O_TX];
  assign irq_rtim  = lines[O_RT];
  assign irq_modem = lines[O_MS];
  assign irq_err   = lines[O_ERR];

  always_comb begin
    case (int'(reg_addr))
      A_MASK:  reg_rdata = {{PAD_W{1'b0}}, mask_q};
      A_RAW:   reg_rdata = {{PAD_W{1'b0}}, raw_q};
      A_MSKD:  reg_rdata = {{PAD_W{1'b0}}, masked};
      default: reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/uart_irq_router_chk.sv
module uart_irq_router_chk
  import uart_irq_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wen,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [NSRC-1:0]   ev_set,
  input logic [NSRC-1:0]   ev_clr,
  input logic [NSRC-1:0]   raw_q,
  input logic [NSRC-1:0]   mask_q,
  input logic              irq_all,
  input logic              irq_rx,
  input logic              irq_tx,
  input logic              irq_rtim,
  input logic              irq_modem,
  input logic              irq_err
);

  // R4, R7: a set strobe always lands, whatever clears arrive with it
  a_r4_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_set != '0) |=> ((raw_q & $past(ev_set)) == $past(ev_set)));

  // R5: software clear removes written bits that were not set again
  a_r5_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wen && reg_addr == ADDR_W'(A_CLR))
      |=> ((raw_q & $past(reg_wdata[NSRC-1:0] & ~ev_set)) == '0));

  // R6: hardware clear removes bits that were not set again
  a_r6_hw_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_clr != '0) |=> ((raw_q & $past(ev_clr & ~ev_set)) == '0));

  // R8: clear address reads as zero
  a_r8_clr_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(A_CLR)) |-> (reg_rdata == '0));

  // R8: writes to the status addresses change nothing
  a_r8_status_wr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wen && (reg_addr == ADDR_W'(A_RAW) || reg_addr == ADDR_W'(A_MSKD))
      && ev_set == '0 && ev_clr == '0) |=> ($stable(raw_q) && $stable(mask_q)));

  // R9: transmit data write raises the transmit bit
  a_r9_tx_on_data: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wen && reg_addr == ADDR_W'(A_DATA)) |=> raw_q[B_TX]);

  // R10: combined line is exactly the OR of the five group lines
  a_r10_combined: assert property (@(posedge clk) disable iff (!rst_n)
    irq_all == (irq_rx | irq_tx | irq_rtim | irq_modem | irq_err));

  // R10: receive line tracks its masked bit
  a_r10_rx_line: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx == (raw_q[B_RX] && mask_q[B_RX]));

endmodule

bind uart_irq_router uart_irq_router_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/uart_irq_router_tb.sv
`timescale 1ns/1ps
module uart_irq_router_tb;

  localparam int AW = 3;
  localparam int DW = 16;
  localparam int NV = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic          reg_wen = 1'b0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic [10:0]   ev_set = '0;
  logic [10:0]   ev_clr = '0;
  logic irq_all, irq_rx, irq_tx, irq_rtim, irq_modem, irq_err;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  uart_irq_router #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wen(reg_wen),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_set(ev_set), .ev_clr(ev_clr),
    .irq_all(irq_all), .irq_rx(irq_rx), .irq_tx(irq_tx), .irq_rtim(irq_rtim),
    .irq_modem(irq_modem), .irq_err(irq_err)
  );

  // vectors: set strobe, mask, expected {all,rx,tx,rtim,modem,err}
  localparam logic [10:0] V_SET [NV] = '{11'h010, 11'h010, 11'h020, 11'h040, 11'h001,
                                         11'h008, 11'h400, 11'h080, 11'h7FF, 11'h004};
  localparam logic [10:0] V_MSK [NV] = '{11'h010, 11'h000, 11'h7FF, 11'h040, 11'h00F,
                                         11'h7F7, 11'h780, 11'h07F, 11'h7FF, 11'h004};
  localparam logic [5:0]  V_EXP [NV] = '{6'b110000, 6'b000000, 6'b101000, 6'b100100,
                                         6'b100010, 6'b000000, 6'b100001, 6'b000000,
                                         6'b111111, 6'b100010};

  function automatic logic [5:0] lines_now();
    return {irq_all, irq_rx, irq_tx, irq_rtim, irq_modem, irq_err};
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive on falling edge, captured at the rising edge, released on next falling edge
  task automatic wr(input int a, input logic [DW-1:0] d);
    reg_addr = AW'(a); reg_wdata = d; reg_wen = 1'b1;
    @(negedge clk);
    reg_wen = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input int a, output logic [DW-1:0] d);
    reg_addr = AW'(a);
    #1 d = reg_rdata;
  endtask

  task automatic strobe(input logic [10:0] s, input logic [10:0] c);
    ev_set = s; ev_clr = c;
    @(negedge clk);
    ev_set = '0; ev_clr = '0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v;
    repeat (3) @(negedge clk);
    // R1: reset state
    rd(1, v); chk("R1 mask after reset", v, 16'h0);
    rd(2, v); chk("R1 raw after reset", v, 16'h0);
    chk("R1 lines after reset", 16'(lines_now()), 16'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // vector walk: R3, R4, R10, R11
    for (int i = 0; i < NV; i++) begin
      wr(4, 16'h07FF);
      wr(1, 16'(V_MSK[i]));
      strobe(V_SET[i], '0);
      chk($sformatf("R10 R11 lines vec%0d", i), 16'(lines_now()), 16'(V_EXP[i]));
      rd(2, v); chk($sformatf("R3 R4 raw vec%0d", i), v, 16'(V_SET[i]));
      rd(3, v); chk($sformatf("R3 masked vec%0d", i), v, 16'(V_SET[i] & V_MSK[i]));
    end

    // R2: mask readback, upper bits zero
    wr(1, 16'hFFFF);
    rd(1, v); chk("R2 mask readback", v, 16'h07FF);
    wr(1, 16'h0155);
    rd(1, v); chk("R2 mask readback pattern", v, 16'h0155);

    // R5: partial clear
    wr(4, 16'h07FF);
    strobe(11'h0F0, '0);
    wr(4, 16'h0030);
    rd(2, v); chk("R5 partial clear", v, 16'h00C0);

    // R6: hardware clear
    strobe('0, 11'h040);
    rd(2, v); chk("R6 hw clear", v, 16'h0080);

    // R7: set beats software clear in the same cycle
    reg_addr = AW'(4); reg_wdata = 16'h0001; reg_wen = 1'b1; ev_set = 11'h001;
    @(negedge clk);
    reg_wen = 1'b0; ev_set = '0;
    rd(2, v); chk("R7 set beats sw clear", v, 16'h0081);
    // R7: set beats hardware clear
    strobe(11'h080, 11'h080);
    rd(2, v); chk("R7 set beats hw clear", v, 16'h0081);

    // R8: clear reads zero, status writes ignored
    rd(4, v); chk("R8 clear reads zero", v, 16'h0);
    wr(2, 16'h07FF);
    rd(2, v); chk("R8 raw write ignored", v, 16'h0081);
    wr(3, 16'h0000);
    rd(2, v); chk("R8 masked write raw kept", v, 16'h0081);
    rd(1, v); chk("R8 masked write mask kept", v, 16'h0155);

    // R9: data write sets transmit bit, line follows
    wr(4, 16'h07FF);
    wr(1, 16'h0020);
    chk("R9 tx line low before", 16'(irq_tx), 16'h0);
    wr(0, 16'h0041);
    rd(2, v); chk("R9 data write sets tx", v, 16'h0020);
    chk("R9 R10 tx line high", 16'(lines_now()), 16'(6'b101000));

    // R11: mask change alone updates the lines after its edge
    wr(1, 16'h0000);
    chk("R11 mask off drops lines", 16'(lines_now()), 16'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule